// File: doc/BRIEF.md
# Dual-Counter Windowed Watchdog

This block supervises software with two separate tick counters. The active counter advances only in cycles where the `tick` enable is high. It runs while the system is awake and issues a one-cycle reset request if software fails to service it in time. Software services it by writing a 16-bit key to the write port. With window mode on, a key that arrives too early also raises the reset request. The idle counter runs only while the system is in a low-power state. It starts from zero on every entry and raises a wake request when it expires, so it can end a sleep or idle period after a set time.

Each counter has its own 5-bit postscaler strap, which sets a period of 2^N ticks. One shared enable bit controls both counters. A configuration strap can force that bit on, and another strap can force window mode on. A sticky status flag records that a timeout happened, and software can write it. A four-state machine sequences the block:
- `ST_OFF`: both counters are held at zero.
- `ST_RUN`: the active counter counts.
- `ST_SAVE`: the system is in low power. The active counter is frozen and the idle counter counts.
- `ST_WAKE`: the idle counter has expired. The wake request is held and the active counter counts again.

The transitions are:
- Enable rise: `ST_OFF` to `ST_RUN`.
- `pwr_save` rise: `ST_RUN` to `ST_SAVE`.
- Idle expiry: `ST_SAVE` to `ST_WAKE`.
- `pwr_save` fall: `ST_SAVE` or `ST_WAKE` to `ST_RUN`. From `ST_SAVE` this is an early wake caused by some other event.
- Enable fall: any state to `ST_OFF`.

Top module: `twin_watchdog`

## Requirements
- R1: A write with `wr_sel`=1 and `wr_data`=0x5743 clears the active counter. Any other data value at select 1 leaves the count unchanged.
- R2: The active counter expires on the 2^N-th tick after it was last cleared, where N is `cfg_run_div`. `rst_req` is then high for exactly the following cycle, and the count restarts from zero.
- R3: In window mode, a key is accepted once the count is at least P − floor(P·F), where P=2^N. F is set by `cfg_win_sel`: 3 gives 25%, 2 gives 37.5%, 1 gives 50% and 0 gives 75%. The threshold is never above P−1, so for N=0 the terminal count is the window.
- R4: In window mode, a valid key below the threshold raises `rst_req` in the next cycle. A valid key inside the window raises no reset and restarts the count.
- R5: `on_q` equals `cfg_force_on` OR a software bit. The software bit is `wr_data[0]` of a write at select 0 and is 0 after reset. While the strap is set, writing 0 leaves `on_q` at 1.
- R6: `win_q` equals `cfg_force_win` OR a software bit. The software bit is `wr_data[1]` of a write at select 0. While the strap is set, writing 0 leaves `win_q` at 1.
- R7: While `pwr_save` is high, the active counter keeps its count without advancing. The idle counter starts from zero on each entry, and window mode does not apply.
- R8: The idle counter expires after 2^M ticks, where M is `cfg_save_div`. Then `wake_req` goes high and stays high until `pwr_save` falls, `to_flag` is set, and the active counter resumes from its held count.
- R9: If `pwr_save` falls before the idle counter expires, no wake is raised. The active counter continues from its held value, and the next entry restarts the idle count.
- R10: A one-cycle pulse on `dbg_clr` or on `clk_sw_clr` clears the active counter.
- R11: `to_flag` is set by any timeout and stays set. A write at select 2 loads it from `wr_data[0]`, and writing 1 raises no reset.
- R12: While `on_q` is 0, neither counter advances and no reset or wake is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Counting enable; one count per high cycle |
| cfg_force_on | input | 1 | Strap forcing the enable on |
| cfg_force_win | input | 1 | Strap forcing window mode on |
| cfg_win_sel | input | 2 | Window size code |
| cfg_run_div | input | 5 | Active-counter postscaler N |
| cfg_save_div | input | 5 | Idle-counter postscaler M |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 control, 1 key, 2 status flag |
| wr_data | input | 16 | Write data |
| pwr_save | input | 1 | High while in sleep or idle |
| dbg_clr | input | 1 | Debug clear strobe |
| clk_sw_clr | input | 1 | Clock-switch clear strobe |
| rst_req | output | 1 | One-cycle system reset request |
| wake_req | output | 1 | Wake request from the idle counter |
| to_flag | output | 1 | Sticky timeout status |
| on_q | output | 1 | Effective enable |
| win_q | output | 1 | Effective window mode |

## Verification
The bench targets the first tick of the window and the last tick before it, for every window code and several periods, including the clamped threshold at small N. A design with an off-by-one threshold would either reset on a legitimate service or accept an early one. It also checks that a near-miss key value has no effect, and that the active count survives a sleep period. A design that cleared the active count on low-power entry or exit would delay its reset, which the tick counts expose. An early wake followed by re-entry checks that the idle count restarts. Carrying the idle count over would wake the system too soon.

// File: rtl/twdt_pkg.sv
package twdt_pkg;
    localparam int DATA_W = 16;
    localparam logic [DATA_W-1:0] SERVICE_KEY = 16'h5743;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_KEY  = 2'd1;
    localparam logic [1:0] SEL_FLAG = 2'd2;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_SAVE = 2'd2,
        ST_WAKE = 2'd3
    } wdt_state_t;
endpackage

// File: rtl/twdt_counter.sv
module twdt_counter #(
    parameter int DIV_W = 5,
    localparam int CNT_W = 1 << DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [DIV_W-1:0] div,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    logic [CNT_W-1:0] term;

    // terminal count is 2^div - 1
    assign term   = ~({CNT_W{1'b1}} << div);
    assign expire = adv && (cnt == term);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (expire) cnt <= '0;
        else if (adv)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/twdt_window.sv
module twdt_window #(
    parameter int DIV_W = 5,
    localparam int CNT_W = 1 << DIV_W,
    localparam int EXT_W = CNT_W + 4
) (
    input  logic [DIV_W-1:0] div,
    input  logic [1:0]       win_sel,
    output logic [CNT_W-1:0] thr
);
    logic [EXT_W-1:0] period;
    logic [EXT_W-1:0] eighths;
    logic [EXT_W-1:0] share;
    logic [EXT_W-1:0] raw;

    always_comb begin
        period = {{(EXT_W-1){1'b0}}, 1'b1} << div;
        unique case (win_sel)
            2'd3:    eighths = EXT_W'(2);
            2'd2:    eighths = EXT_W'(3);
            2'd1:    eighths = EXT_W'(4);
            default: eighths = EXT_W'(6);
        endcase
        share = (period * eighths) >> 3;
        raw   = period - share;
        if (raw > period - 1'b1) raw = period - 1'b1;
        thr = raw[CNT_W-1:0];
    end
endmodule

// File: rtl/twdt_regs.sv
module twdt_regs
    import twdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_force_on,
    input  logic              cfg_force_win,
    input  logic              flag_set,
    output logic              on_q,
    output logic              win_q,
    output logic              flag_q,
    output logic              key_ok
);
    logic on_sw;
    logic win_sw;

    assign on_q   = cfg_force_on | on_sw;
    assign win_q  = cfg_force_win | win_sw;
    assign key_ok = wr_en && (wr_sel == SEL_KEY) && (wr_data == SERVICE_KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_sw  <= 1'b0;
            win_sw <= 1'b0;
        end else if (wr_en && wr_sel == SEL_CTRL) begin
            on_sw  <= wr_data[0];
            win_sw <= wr_data[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            flag_q <= 1'b0;
        else if (flag_set)                     flag_q <= 1'b1;
        else if (wr_en && wr_sel == SEL_FLAG)  flag_q <= wr_data[0];
    end
endmodule

// File: rtl/twin_watchdog.sv
module twin_watchdog
    import twdt_pkg::*;
#(
    parameter int DIV_W = 5,
    localparam int CNT_W = 1 << DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cfg_force_on,
    input  logic              cfg_force_win,
    input  logic [1:0]        cfg_win_sel,
    input  logic [DIV_W-1:0]  cfg_run_div,
    input  logic [DIV_W-1:0]  cfg_save_div,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pwr_save,
    input  logic              dbg_clr,
    input  logic              clk_sw_clr,
    output logic              rst_req,
    output logic              wake_req,
    output logic              to_flag,
    output logic              on_q,
    output logic              win_q
);
    wdt_state_t state, state_nx;

    logic             key_ok;
    logic             run_adv, save_adv, save_clr, run_clr;
    logic             run_expire, save_expire;
    logic             early_key;
    logic             run_phase;
    logic [CNT_W-1:0] run_cnt, save_cnt, win_thr;

    twdt_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .cfg_force_on (cfg_force_on),
        .cfg_force_win(cfg_force_win),
        .flag_set     (run_expire | save_expire),
        .on_q         (on_q),
        .win_q        (win_q),
        .flag_q       (to_flag),
        .key_ok       (key_ok)
    );

    twdt_counter #(.DIV_W(DIV_W)) u_run_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (run_clr),
        .adv   (run_adv),
        .div   (cfg_run_div),
        .cnt   (run_cnt),
        .expire(run_expire)
    );

    twdt_counter #(.DIV_W(DIV_W)) u_save_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (save_clr),
        .adv   (save_adv),
        .div   (cfg_save_div),
        .cnt   (save_cnt),
        .expire(save_expire)
    );

    twdt_window #(.DIV_W(DIV_W)) u_window (
        .div    (cfg_run_div),
        .win_sel(cfg_win_sel),
        .thr    (win_thr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:  if (on_q) state_nx = ST_RUN;
            ST_RUN: begin
                if (!on_q)         state_nx = ST_OFF;
                else if (pwr_save) state_nx = ST_SAVE;
            end
            ST_SAVE: begin
                if (!on_q)            state_nx = ST_OFF;
                else if (save_expire) state_nx = ST_WAKE;
                else if (!pwr_save)   state_nx = ST_RUN;
            end
            ST_WAKE: begin
                if (!on_q)          state_nx = ST_OFF;
                else if (!pwr_save) state_nx = ST_RUN;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // per-state outputs and counter controls
    always_comb begin
        run_phase = (state == ST_RUN) || (state == ST_WAKE);
        run_adv   = tick && on_q && run_phase;
        save_adv  = tick && on_q && (state == ST_SAVE);
        save_clr  = (state != ST_SAVE);
        run_clr   = !on_q || key_ok || dbg_clr || clk_sw_clr;
        early_key = key_ok && on_q && win_q && run_phase && (run_cnt < win_thr);
        wake_req  = (state == ST_WAKE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= run_expire | early_key;
    end
endmodule

// File: rtl/twin_watchdog_chk.sv
module twin_watchdog_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_force_on,
    input logic cfg_force_win,
    input logic pwr_save,
    input logic rst_req,
    input logic wake_req,
    input logic to_flag,
    input logic on_q,
    input logic win_q
);
    // R12
    rst_needs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(on_q));

    // R5
    on_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_force_on |-> on_q);

    // R6
    win_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_force_win |-> win_q);

    // R8
    wake_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> to_flag);

    // R8
    wake_in_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> $past(pwr_save));

    // R2
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req || $past(on_q));
endmodule

bind twin_watchdog twin_watchdog_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_force_on (cfg_force_on),
    .cfg_force_win(cfg_force_win),
    .pwr_save     (pwr_save),
    .rst_req      (rst_req),
    .wake_req     (wake_req),
    .to_flag      (to_flag),
    .on_q         (on_q),
    .win_q        (win_q)
);

// File: tb/twin_watchdog_test.sv
module twin_watchdog_test;
    localparam int CLK_PERIOD = 10;
    localparam int SEED = 20240611;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        cfg_force_on = 1'b0, cfg_force_win = 1'b0;
    logic [1:0]  cfg_win_sel = 2'd0;
    logic [4:0]  cfg_run_div = 5'd0, cfg_save_div = 5'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        pwr_save = 1'b0, dbg_clr = 1'b0, clk_sw_clr = 1'b0;
    logic        rst_req, wake_req, to_flag, on_q, win_q;

    int n_chk = 0, n_fail = 0, rst_seen = 0;
    bit done = 0;

    twin_watchdog uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cfg_force_on(cfg_force_on), .cfg_force_win(cfg_force_win),
        .cfg_win_sel(cfg_win_sel), .cfg_run_div(cfg_run_div), .cfg_save_div(cfg_save_div),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pwr_save(pwr_save), .dbg_clr(dbg_clr), .clk_sw_clr(clk_sw_clr),
        .rst_req(rst_req), .wake_req(wake_req), .to_flag(to_flag),
        .on_q(on_q), .win_q(win_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (rst_n && rst_req) rst_seen++;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_dbg();
        @(negedge clk) dbg_clr = 1'b1;
        @(negedge clk) dbg_clr = 1'b0;
    endtask

    function automatic int exp_thr(input int n, input int w);
        int p, pct10, t;
        p = 1 << n;
        case (w)
            3: pct10 = 250;
            2: pct10 = 375;
            1: pct10 = 500;
            default: pct10 = 750;
        endcase
        t = p - (p * pct10) / 1000;
        if (t > p - 1) t = p - 1;
        return t;
    endfunction

    initial begin
        idle(150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int base, p, t, k, th, n, w;
        void'($urandom(SEED));
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // reset state
        chk("R5 reset on", on_q, 0);
        chk("R11 reset flag", to_flag, 0);
        chk("R2 reset rst_req", rst_req, 0);
        chk("R8 reset wake", wake_req, 0);

        // R12: disabled, nothing counts
        base = rst_seen;
        ticks(20);
        idle(1);
        chk("R12 no reset while off", rst_seen - base, 0);

        // R5: enable via software
        wr(2'd0, 16'h0001);
        idle(2);
        chk("R5 sw on", on_q, 1);

        // R2 directed: N=2
        cfg_run_div = 5'd2;
        pulse_dbg();
        base = rst_seen;
        ticks(3); idle(1);
        chk("R2 before expiry", rst_seen - base, 0);
        ticks(1); idle(1);
        chk("R2 at expiry", rst_seen - base, 1);
        chk("R11 flag after run timeout", to_flag, 1);

        // R11: write 0 clears, write 1 sets without reset
        wr(2'd2, 16'h0000);
        chk("R11 flag cleared", to_flag, 0);
        base = rst_seen;
        wr(2'd2, 16'h0001);
        idle(1);
        chk("R11 flag set by write", to_flag, 1);
        chk("R11 no reset from flag write", rst_seen - base, 0);
        wr(2'd2, 16'h0000);

        // R1: wrong key ignored, right key clears
        cfg_run_div = 5'd3;
        pulse_dbg();
        base = rst_seen;
        ticks(5);
        wr(2'd1, 16'h5742);
        ticks(3); idle(1);
        chk("R1 wrong key ignored", rst_seen - base, 1);
        pulse_dbg();
        base = rst_seen;
        ticks(5);
        wr(2'd1, 16'h5743);
        ticks(7); idle(1);
        chk("R1 key clears count", rst_seen - base, 0);
        ticks(1); idle(1);
        chk("R1 full period after key", rst_seen - base, 1);

        // R10: debug and clock-switch clears
        pulse_dbg();
        base = rst_seen;
        ticks(6);
        @(negedge clk) clk_sw_clr = 1'b1;
        @(negedge clk) clk_sw_clr = 1'b0;
        ticks(7); idle(1);
        chk("R10 clock switch clear", rst_seen - base, 0);
        pulse_dbg();
        ticks(7); idle(1);
        chk("R10 debug clear", rst_seen - base, 0);

        // R2 random periods
        for (int trial = 0; trial < 16; trial++) begin
            n = $urandom_range(0, 4);
            p = 1 << n;
            t = $urandom_range(0, 3 * p);
            cfg_run_div = 5'(n);
            pulse_dbg();
            base = rst_seen;
            ticks(t); idle(1);
            chk($sformatf("R2 random N=%0d t=%0d", n, t), rst_seen - base, t / p);
        end

        // R6: window enable via software
        wr(2'd0, 16'h0003);
        chk("R6 sw window", win_q, 1);

        // R3/R4 directed: N=3, code 3 -> threshold 6
        cfg_run_div = 5'd3; cfg_win_sel = 2'd3;
        pulse_dbg();
        base = rst_seen;
        ticks(5);
        wr(2'd1, 16'h5743); idle(1);
        chk("R4 early key resets", rst_seen - base, 1);
        pulse_dbg();
        base = rst_seen;
        ticks(6);
        wr(2'd1, 16'h5743); idle(1);
        chk("R3 key at window start accepted", rst_seen - base, 0);
        // R3: N=0 window is the terminal count
        cfg_run_div = 5'd0;
        pulse_dbg();
        base = rst_seen;
        wr(2'd1, 16'h5743); idle(1);
        chk("R3 N=0 key accepted", rst_seen - base, 0);

        // R3/R4 random windows
        for (int trial = 0; trial < 24; trial++) begin
            n = $urandom_range(1, 4);
            w = $urandom_range(0, 3);
            p = 1 << n;
            k = $urandom_range(0, p - 1);
            th = exp_thr(n, w);
            cfg_run_div = 5'(n); cfg_win_sel = 2'(w);
            pulse_dbg();
            base = rst_seen;
            ticks(k);
            wr(2'd1, 16'h5743); idle(1);
            chk($sformatf("R3 R4 N=%0d code=%0d k=%0d", n, w, k),
                rst_seen - base, (k < th) ? 1 : 0);
        end

        // R6: window off again; forced straps
        wr(2'd0, 16'h0001);
        chk("R6 sw window off", win_q, 0);
        cfg_force_win = 1'b1;
        wr(2'd0, 16'h0001);
        chk("R6 forced window stays", win_q, 1);
        cfg_force_win = 1'b0;
        wr(2'd0, 16'h0001);

        // R7/R8: timed wake and run count hold
        cfg_run_div = 5'd3; cfg_save_div = 5'd2;
        wr(2'd2, 16'h0000);
        pulse_dbg();
        base = rst_seen;
        ticks(3);
        @(negedge clk) pwr_save = 1'b1;
        idle(2);
        ticks(3); idle(1);
        chk("R8 no wake early", wake_req, 0);
        ticks(1);
        chk("R8 wake on expiry", wake_req, 1);
        chk("R8 flag on wake", to_flag, 1);
        idle(3);
        chk("R8 wake held", wake_req, 1);
        @(negedge clk) pwr_save = 1'b0;
        idle(2);
        chk("R8 wake drops", wake_req, 0);
        ticks(4); idle(1);
        chk("R7 run count held in save", rst_seen - base, 0);
        ticks(1); idle(1);
        chk("R7 run resumes from held count", rst_seen - base, 1);

        // R9: other-event wake
        wr(2'd2, 16'h0000);
        pulse_dbg();
        base = rst_seen;
        ticks(2);
        @(negedge clk) pwr_save = 1'b1;
        idle(2);
        ticks(3);
        @(negedge clk) pwr_save = 1'b0;
        idle(2);
        chk("R9 no wake on other event", wake_req, 0);
        chk("R9 no flag on other event", to_flag, 0);
        ticks(5); idle(1);
        chk("R9 run continues", rst_seen - base, 0);
        @(negedge clk) pwr_save = 1'b1;
        idle(2);
        ticks(3); idle(1);
        chk("R9 save count restarted", wake_req, 0);
        ticks(1);
        chk("R9 wake after full period", wake_req, 1);
        @(negedge clk) pwr_save = 1'b0;
        idle(2);

        // R5: forced enable cannot be cleared
        cfg_force_on = 1'b1;
        wr(2'd0, 16'h0000);
        chk("R5 forced on stays", on_q, 1);
        cfg_force_on = 1'b0;
        idle(1);
        chk("R5 off without strap", on_q, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule